// File: doc/BRIEF.md
# Wake-up Call Controller

This block runs the digital side of a sensor node's auxiliary wake-up link. It watches the digitized on-off-keyed line from the wake-up receiver's comparator and recovers Manchester bits from the line's transitions. It then checks the frame's sync word, parity, type and address, and takes one of three actions. It can pulse a wake line to the host microcontroller, relay a wake-up call to the next hop on the route, or drop the frame. The host microcontroller can also ask the block to send a wake-up call to the next hop. Outgoing frames are Manchester-coded straight onto the emitter's data pin. The emitter enable is raised only while a frame is on the air.

While nothing is happening, the block holds a low-power request so that the surrounding power-mode logic can freeze the device. The first rising edge of an incoming frame pulls the block out of that state. That edge is also the first half of the first sync bit, so no part of the frame is lost. The host never has to wake up to inspect calls meant for other nodes. Two address registers, one for the node itself and one for the next hop, are written through a small host port.

Top module: `wakeup_ctrl`

## Requirements
- R1: After reset and whenever the block is idle, `lp_req` is 1 and `tx_en`, `tx_data` and `host_wake` are 0.
- R2: Line coding is Manchester with HALF_BIT clock cycles per half bit. A 1 is high then low and a 0 is low then high, and the idle line is low. The first rising edge from idle starts reception, and that edge belongs to the first frame bit. `lp_req` is 0 while a frame is being received.
- R3: A frame is 21 bits, sent most significant bit first: sync 8'b10101011, then a 4-bit type, an 8-bit address and one parity bit. The parity bit makes the count of ones over type, address and parity even.
- R4: A valid frame of type 4'h3 (wake) carrying the own address gives exactly one `host_wake` pulse, one cycle long, and no transmission.
- R5: A valid frame of type 4'h6 (relay) carrying the own address makes the block transmit a type 4'h3 frame addressed to the next hop, and it does not wake the host.
- R6: A valid frame whose address is not the own address is dropped silently. This includes frames carrying the next-hop address: no wake and no transmission follow.
- R7: A frame with wrong parity, a wrong sync word or a type other than 4'h3 and 4'h6 is dropped with no wake and no transmission.
- R8: A bit with no mid-bit transition aborts reception. The partial frame is dropped, the block returns to idle, and a later good frame is still accepted.
- R9: If the line stops toggling partway through a frame, the block is back in idle (`lp_req` = 1) within four half-bit periods of the last edge, with no wake and no transmission.
- R10: A one-cycle `host_req` while idle makes the block transmit a type 4'h3 frame addressed to the next hop.
- R11: `tx_en` is 1 for exactly the 21 bit periods of an outgoing frame, with `tx_data` Manchester-coded as in R2. Once the frame ends, `lp_req` returns to 1.
- R12: A host write with `cfg_we` = 1 loads `cfg_addr` into the own address when `cfg_sel` = 0 and into the next-hop address when `cfg_sel` = 1. The new value governs all later frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Digitized receiver comparator output, Manchester-coded |
| host_req | input | 1 | Host request to send a wake-up call to the next hop |
| cfg_we | input | 1 | Address register write strobe |
| cfg_sel | input | 1 | Register select: 0 own address, 1 next-hop address |
| cfg_addr | input | ADDR_W | Address value to write |
| tx_data | output | 1 | Emitter data pin, Manchester-coded |
| tx_en | output | 1 | Emitter enable, high only during transmission |
| host_wake | output | 1 | One-cycle wake pulse to the host |
| lp_req | output | 1 | Low-power request, high while idle |

## Verification
The bench builds the block with HALF_BIT = 8 and ADDR_W = 8. A full frame then lasts 336 cycles, so about a dozen incoming and outgoing frames fit easily in one run. A short half bit places the receiver's sample points four cycles into each half. The bench can hit them exactly with its own generator and then decode the emitter output at matching points. With that setting, the stall window of four half bits is only 32 cycles. Broken bits and frames cut short can therefore be checked right after the last edge rather than after a long wait.

// File: rtl/wuc_pkg.sv
package wuc_pkg;
  localparam int TYPE_W = 4;
  localparam int SYNC_W = 8;
  localparam logic [SYNC_W-1:0] SYNC_WORD = 8'b10101011;
  localparam logic [TYPE_W-1:0] T_WAKE  = 4'h3;
  localparam logic [TYPE_W-1:0] T_RELAY = 4'h6;
  typedef enum logic [1:0] {C_SLEEP, C_RX, C_TX} ctl_state_t;
endpackage

// File: rtl/wuc_manchester_rx.sv
module wuc_manchester_rx #(
  parameter int HALF_BIT = 8,
  parameter int NBITS    = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             line_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             abort_o,
  output logic [NBITS-1:0] bits_o
);
  localparam int CW = $clog2(3 * HALF_BIT);
  localparam int IW = $clog2(NBITS + 1);
  localparam logic [CW-1:0] SAMPLE_AT = CW'(HALF_BIT + HALF_BIT / 2);
  localparam logic [CW-1:0] LATE_AT   = CW'(HALF_BIT);
  localparam logic [CW-1:0] PRELOAD   = CW'(HALF_BIT);

  typedef enum logic [1:0] {R_IDLE, R_SAMPLE, R_EDGE} rx_state_t;
  rx_state_t       st;
  logic [2:0]      sync_q;
  logic [CW-1:0]   cnt;
  logic [IW-1:0]   nbit;
  logic            half1;
  logic            line_s, line_p;

  assign line_s = sync_q[1];
  assign line_p = sync_q[2];
  assign busy_o = (st != R_IDLE);

  // Timing is re-anchored on every mid-bit transition.
  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= R_IDLE;
      sync_q  <= '0;
      cnt     <= '0;
      nbit    <= '0;
      half1   <= 1'b0;
      done_o  <= 1'b0;
      abort_o <= 1'b0;
      bits_o  <= '0;
    end else begin
      sync_q  <= {sync_q[1:0], line_i};
      done_o  <= 1'b0;
      abort_o <= 1'b0;
      case (st)
        R_IDLE: if (en && line_s && !line_p) begin
          st   <= R_SAMPLE;
          cnt  <= PRELOAD;
          nbit <= '0;
        end
        R_SAMPLE: if (cnt == SAMPLE_AT) begin
          half1 <= line_s;
          cnt   <= '0;
          st    <= R_EDGE;
        end else begin
          cnt <= cnt + 1'b1;
        end
        R_EDGE: if (line_s != half1) begin
          bits_o <= {bits_o[NBITS-2:0], half1};
          cnt    <= '0;
          if (nbit == IW'(NBITS - 1)) begin
            done_o <= 1'b1;
            st     <= R_IDLE;
          end else begin
            nbit <= nbit + 1'b1;
            st   <= R_SAMPLE;
          end
        end else if (cnt == LATE_AT) begin
          abort_o <= 1'b1;
          st      <= R_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= R_IDLE;
      endcase
    end
  end

  assert_done_abort_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(done_o && abort_o));
endmodule

// File: rtl/wuc_manchester_tx.sv
module wuc_manchester_tx #(
  parameter int HALF_BIT = 8,
  parameter int NBITS    = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [NBITS-1:0] frame_i,
  output logic             data_o,
  output logic             en_o,
  output logic             done_o
);
  localparam int HW = $clog2(HALF_BIT + 1);
  localparam int IW = $clog2(NBITS + 1);
  localparam logic [HW-1:0] HALF_LAST = HW'(HALF_BIT - 1);

  logic [NBITS-1:0] sh;
  logic [HW-1:0]    hc;
  logic [IW-1:0]    left;
  logic             second;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      hc     <= '0;
      left   <= '0;
      second <= 1'b0;
      data_o <= 1'b0;
      en_o   <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!en_o) begin
        if (start_i) begin
          en_o   <= 1'b1;
          data_o <= frame_i[NBITS-1];
          sh     <= frame_i;
          hc     <= '0;
          second <= 1'b0;
          left   <= IW'(NBITS - 1);
        end
      end else if (hc != HALF_LAST) begin
        hc <= hc + 1'b1;
      end else begin
        hc <= '0;
        if (!second) begin
          second <= 1'b1;
          data_o <= ~sh[NBITS-1];
        end else if (left == '0) begin
          en_o   <= 1'b0;
          data_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          second <= 1'b0;
          left   <= left - 1'b1;
          sh     <= {sh[NBITS-2:0], 1'b0};
          data_o <= sh[NBITS-2];
        end
      end
    end
  end

  assert_quiet_when_off_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(en_o) |-> done_o);
endmodule

// File: rtl/wakeup_ctrl.sv
module wakeup_ctrl
  import wuc_pkg::*;
#(
  parameter int HALF_BIT = 8,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_line,
  input  logic              host_req,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_addr,
  output logic              tx_data,
  output logic              tx_en,
  output logic              host_wake,
  output logic              lp_req
);
  localparam int NBITS = SYNC_W + TYPE_W + ADDR_W + 1;

  ctl_state_t        st;
  logic [ADDR_W-1:0] own_q, hop_q;
  logic              rx_busy, rx_done, rx_abort, tx_done, tx_go;
  logic [NBITS-1:0]  rx_bits, out_frame;
  logic [SYNC_W-1:0] f_sync;
  logic [TYPE_W-1:0] f_type;
  logic [ADDR_W-1:0] f_addr;
  logic              f_ok;

  wuc_manchester_rx #(.HALF_BIT(HALF_BIT), .NBITS(NBITS)) u_rx (
    .clk(clk), .rst(rst), .en(st != C_TX), .line_i(rx_line),
    .busy_o(rx_busy), .done_o(rx_done), .abort_o(rx_abort), .bits_o(rx_bits));

  wuc_manchester_tx #(.HALF_BIT(HALF_BIT), .NBITS(NBITS)) u_tx (
    .clk(clk), .rst(rst), .start_i(tx_go), .frame_i(out_frame),
    .data_o(tx_data), .en_o(tx_en), .done_o(tx_done));

  assign f_sync    = rx_bits[NBITS-1 -: SYNC_W];
  assign f_type    = rx_bits[ADDR_W+1 +: TYPE_W];
  assign f_addr    = rx_bits[1 +: ADDR_W];
  assign f_ok      = (f_sync == SYNC_WORD) && !(^rx_bits[ADDR_W+TYPE_W:0])
                     && (f_addr == own_q);
  assign out_frame = {SYNC_WORD, T_WAKE, hop_q, ^{T_WAKE, hop_q}};

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= C_SLEEP;
      own_q     <= '0;
      hop_q     <= '0;
      host_wake <= 1'b0;
      lp_req    <= 1'b1;
      tx_go     <= 1'b0;
    end else begin
      host_wake <= 1'b0;
      tx_go     <= 1'b0;
      if (cfg_we) begin
        if (cfg_sel) hop_q <= cfg_addr;
        else         own_q <= cfg_addr;
      end
      case (st)
        C_SLEEP: if (rx_busy) begin
          st     <= C_RX;
          lp_req <= 1'b0;
        end else if (host_req) begin
          st     <= C_TX;
          lp_req <= 1'b0;
          tx_go  <= 1'b1;
        end
        C_RX: if (rx_abort) begin
          st     <= C_SLEEP;
          lp_req <= 1'b1;
        end else if (rx_done) begin
          if (f_ok && f_type == T_WAKE) begin
            host_wake <= 1'b1;
            st        <= C_SLEEP;
            lp_req    <= 1'b1;
          end else if (f_ok && f_type == T_RELAY) begin
            st    <= C_TX;
            tx_go <= 1'b1;
          end else begin
            st     <= C_SLEEP;
            lp_req <= 1'b1;
          end
        end
        C_TX: if (tx_done) begin
          st     <= C_SLEEP;
          lp_req <= 1'b1;
        end
        default: st <= C_SLEEP;
      endcase
    end
  end

  assert_txen_in_tx_R11: assert property (@(posedge clk) disable iff (rst)
    tx_en |-> (st == C_TX));
  assert_back_to_lp_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_en) |=> lp_req);
  assert_wake_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    host_wake |=> !host_wake);
  assert_one_outcome_R4: assert property (@(posedge clk) disable iff (rst)
    !(host_wake && tx_en));
  assert_lp_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    lp_req |-> (!tx_en && !tx_data));
endmodule

// File: tb/tb_wakeup_ctrl.sv
module tb_wakeup_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int AW = 8;
  localparam int NB = 21;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_line = 1'b0;
  logic host_req = 1'b0;
  logic cfg_we = 1'b0;
  logic cfg_sel = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic tx_data, tx_en, host_wake, lp_req;

  int checks = 0;
  int errors = 0;
  int wake_cnt = 0;
  int txs_cnt = 0;
  logic txen_prev = 1'b0;
  logic lp_seen_low;
  logic [AW-1:0] own_a, hop_a;

  wakeup_ctrl #(.HALF_BIT(HALF), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .rx_line(rx_line), .host_req(host_req),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr),
    .tx_data(tx_data), .tx_en(tx_en), .host_wake(host_wake), .lp_req(lp_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (host_wake) wake_cnt++;
    if (tx_en && !txen_prev) txs_cnt++;
    txen_prev = tx_en;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] mk(input logic [3:0] t, input logic [AW-1:0] a,
                                       input bit bad_par, input logic [7:0] sw);
    return {sw, t, a, (^{t, a}) ^ bad_par};
  endfunction

  // Drive nbits of f; bit index brk (counted from 0) gets no mid-bit transition.
  task automatic send(input logic [NB-1:0] f, input int nbits, input int brk, input bit hold);
    for (int i = 0; i < nbits; i++) begin
      rx_line = f[NB-1-i];
      repeat (HALF) @(negedge clk);
      if (i == 0) lp_seen_low = !lp_req;
      rx_line = (i == brk) ? f[NB-1-i] : ~f[NB-1-i];
      repeat (HALF) @(negedge clk);
    end
    if (!hold) rx_line = 1'b0;
  endtask

  task automatic capture(output logic [NB-1:0] got, output bit ok);
    int n;
    logic a, b;
    got = '0;
    ok = 1'b1;
    n = 0;
    while (!tx_en && n < 600) begin
      @(negedge clk);
      n++;
    end
    if (!tx_en) begin
      ok = 1'b0;
      return;
    end
    for (int i = 0; i < NB; i++) begin
      repeat (HALF/2) @(negedge clk);
      a = tx_data;
      if (!tx_en) ok = 1'b0;
      repeat (HALF) @(negedge clk);
      b = tx_data;
      if (!tx_en || (b != ~a)) ok = 1'b0;
      got = {got[NB-2:0], a};
      repeat (HALF/2) @(negedge clk);
    end
    if (tx_en) ok = 1'b0;
  endtask

  task automatic cfg(input bit sel, input logic [AW-1:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = v;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) hop_a = v; else own_a = v;
  endtask

  task automatic expect_drop(input logic [NB-1:0] f, input string req);
    int w0, t0;
    w0 = wake_cnt; t0 = txs_cnt;
    send(f, NB, -1, 1'b0);
    repeat (4*HALF) @(negedge clk);
    check(wake_cnt == w0, req, wake_cnt - w0, 0);
    check(txs_cnt == t0, req, txs_cnt - t0, 0);
    check(lp_req == 1'b1, req, lp_req, 1);
  endtask

  task automatic t_reset;
    check(lp_req == 1'b1, "R1 reset lp_req", lp_req, 1);
    check(tx_en == 1'b0 && tx_data == 1'b0, "R1 reset emitter", {tx_en, tx_data}, 0);
    check(host_wake == 1'b0, "R1 reset wake", host_wake, 0);
  endtask

  task automatic t_wake_own;
    int w0, t0;
    w0 = wake_cnt; t0 = txs_cnt;
    send(mk(4'h3, own_a, 0, 8'hAB), NB, -1, 1'b0);
    check(lp_seen_low == 1'b1, "R2 lp_req low while receiving", !lp_seen_low, 0);
    repeat (4*HALF) @(negedge clk);
    check(wake_cnt - w0 == 1, "R4 single one-cycle wake pulse", wake_cnt - w0, 1);
    check(txs_cnt == t0, "R4 no transmission", txs_cnt - t0, 0);
    check(lp_req == 1'b1, "R1 idle after wake", lp_req, 1);
  endtask

  task automatic t_relay;
    logic [NB-1:0] got;
    bit ok;
    int w0;
    w0 = wake_cnt;
    fork
      send(mk(4'h6, own_a, 0, 8'hAB), NB, -1, 1'b0);
      capture(got, ok);
    join
    check(ok, "R11 relay frame shape and enable window", ok, 1);
    check(got == mk(4'h3, hop_a, 0, 8'hAB), "R5 relay frame to next hop", got, mk(4'h3, hop_a, 0, 8'hAB));
    check(wake_cnt == w0, "R5 relay does not wake host", wake_cnt - w0, 0);
    repeat (4) @(negedge clk);
    check(lp_req == 1'b1 && tx_en == 1'b0, "R11 idle after transmit", {lp_req, tx_en}, 2);
  endtask

  task automatic t_host;
    logic [NB-1:0] got;
    bit ok;
    host_req = 1'b1;
    @(negedge clk);
    host_req = 1'b0;
    capture(got, ok);
    check(ok, "R11 host frame shape", ok, 1);
    check(got == mk(4'h3, hop_a, 0, 8'hAB), "R10 host call to next hop", got, mk(4'h3, hop_a, 0, 8'hAB));
    repeat (4) @(negedge clk);
    check(lp_req == 1'b1, "R11 lp after host call", lp_req, 1);
  endtask

  task automatic t_mismatch;
    expect_drop(mk(4'h3, 8'h77, 0, 8'hAB), "R6 foreign address");
    expect_drop(mk(4'h3, hop_a, 0, 8'hAB), "R6 next-hop address");
    expect_drop(mk(4'h6, 8'h01, 0, 8'hAB), "R6 foreign relay");
  endtask

  task automatic t_bad;
    expect_drop(mk(4'h3, own_a, 1, 8'hAB), "R7 bad parity");
    expect_drop(mk(4'h3, own_a, 0, 8'hA9), "R7 bad sync");
    expect_drop(mk(4'h9, own_a, 0, 8'hAB), "R7 unknown type R3");
  endtask

  task automatic t_midbit;
    int w0, t0;
    w0 = wake_cnt; t0 = txs_cnt;
    send(mk(4'h3, own_a, 0, 8'hAB), 14, 12, 1'b0);
    repeat (6*HALF) @(negedge clk);
    check(wake_cnt == w0 && txs_cnt == t0, "R8 broken bit dropped",
          wake_cnt - w0 + txs_cnt - t0, 0);
    check(lp_req == 1'b1, "R8 idle after abort", lp_req, 1);
    send(mk(4'h3, own_a, 0, 8'hAB), NB, -1, 1'b0);
    repeat (4*HALF) @(negedge clk);
    check(wake_cnt - w0 == 1, "R8 recovery after abort", wake_cnt - w0, 1);
  endtask

  task automatic t_stall;
    int w0, t0;
    w0 = wake_cnt; t0 = txs_cnt;
    send(mk(4'h3, own_a, 0, 8'hAB), 11, -1, 1'b1);
    repeat (3*HALF) @(negedge clk);
    check(lp_req == 1'b1, "R9 idle within four half bits", lp_req, 1);
    rx_line = 1'b0;
    repeat (4*HALF) @(negedge clk);
    check(wake_cnt == w0 && txs_cnt == t0, "R9 stalled frame dropped",
          wake_cnt - w0 + txs_cnt - t0, 0);
  endtask

  task automatic t_reconfig;
    logic [7:0] old_own;
    int w0;
    old_own = own_a;
    cfg(1'b0, 8'hC3);
    cfg(1'b1, 8'h4E);
    expect_drop(mk(4'h3, old_own, 0, 8'hAB), "R12 old own address");
    w0 = wake_cnt;
    send(mk(4'h3, 8'hC3, 0, 8'hAB), NB, -1, 1'b0);
    repeat (4*HALF) @(negedge clk);
    check(wake_cnt - w0 == 1, "R12 new own address", wake_cnt - w0, 1);
    t_host;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    own_a = '0; hop_a = '0; lp_seen_low = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset;
    cfg(1'b0, 8'h5C);
    cfg(1'b1, 8'h21);
    repeat (4) @(negedge clk);
    t_wake_own;
    t_relay;
    t_host;
    t_mismatch;
    t_bad;
    t_midbit;
    t_stall;
    t_reconfig;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule